// File: doc/BRIEF.md
# Interrupt Injection and Response Monitor

This block sits beside a pipelined processor core in simulation or on an FPGA. It injects external interrupts at a chosen point in the program and then checks how the core responds. Before a run, software loads the configuration through a small register write port. The configuration holds:

- a target instruction address
- a trigger delay
- an action latency
- a mask of the interrupt sources to raise
- one handler entry address for each source
- the expected return address

A start pulse arms the monitor. When the core fetches the target address, the monitor waits the trigger delay and raises every selected line at once. This allows both single-interrupt and concurrent-interrupt cases on the same instruction.

While the lines are up, the monitor checks three things in order:

1. The core fetches the entry address of the highest-priority raised source within the action latency.
2. After the handler signals its exception return, the next fetch lands on the expected return address. This catches a wrong saved address, for example for a multi-cycle instruction that was interrupted.
3. The core acknowledges the interrupt in time. Each line stays high until the acknowledge, or until a fixed hold limit runs out.

The run ends with a done flag, a pass flag and a 3-bit error code. These hold until the next start.

Top module: `irq_inject_monitor`

## Requirements
- R1: While reset is low and in the cycle after it is released, `done`, `pass`, `err_code` and `int_out` are all zero.
- R2: After a start, a non-target fetch raises nothing. If a valid fetch of the target address is presented in cycle m, the lines are first high in cycle m+1+T, where T is the trigger delay.
- R3: The lines raised equal the source mask, all together. The bits are: bit 0 normal interrupt, bit 1 fast interrupt, bit 2 data abort, bit 3 prefetch abort.
- R4: The lines stay at their raised value until the core's acknowledge. They are zero in the cycle after an acknowledge is sampled.
- R5: If no acknowledge arrives, the lines drop after 64 high cycles. The run then ends with error code 5 (timeout).
- R6: The expected entry address belongs to the raised source of highest priority. The order is: data abort, then fast interrupt, then normal interrupt, then prefetch abort. Counting the first high cycle as 0, a fetch of that address is accepted in any cycle up to and including the action latency A.
- R7: If the expected entry has not been fetched by the end of cycle A, the run ends with error code 3 (late entry) and the lines drop.
- R8: If the entry address of any other source is fetched before the expected one, the run ends with error code 2 (wrong entry).
- R9: After entry, an exception-return strobe is awaited. The first valid fetch after it must equal the return register. A match ends with `pass`=1 and code 0. A mismatch ends with code 4 (wrong return).
- R10: If no target fetch is seen in the 256 cycles after start, the run ends with error code 1 (no match).
- R11: The write port map is: 0 target, 1 return address, 2 trigger delay, 3 action latency, 4 source mask, and 5 to 8 the entry addresses of sources 0 to 3.
- R12: `done` and `err_code` hold their result until the next start. A start clears `done` and re-arms the monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | Arms a run |
| fetch_valid | input | 1 | Core presents a fetch this cycle |
| fetch_addr | input | 32 | Fetch address from the core |
| int_ack | input | 1 | Core acknowledges the raised interrupt |
| exc_ret | input | 1 | Core executes its exception return |
| int_out | output | 4 | Interrupt lines to the core |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without error |
| err_code | output | 3 | 0 none, 1 no match, 2 wrong entry, 3 late entry, 4 wrong return, 5 timeout |

## Verification
The hardest situation to reach is an entry fetch that lands in exactly the last cycle of the latency window, or just after it. Both depend on how the trigger delay, the latency and the fetch timing line up. The bench plays the core itself and counts cycles from the target fetch. It sweeps every trigger delay from 0 to 3, every non-empty source mask, every latency from 0 to 3, and every entry cycle from 0 to one past the window. Each combination therefore hits the boundary on both sides. The wrong-entry, hold-timeout and no-match paths are driven in separate runs.

// File: rtl/iim_pkg.sv
// Shared types for the interrupt injection monitor.
// Assumes four sources, indexed by their bit in the line vector.
package iim_pkg;
    localparam int NSRC     = 4;
    localparam int SRC_IRQ  = 0;
    localparam int SRC_FIQ  = 1;
    localparam int SRC_DABT = 2;
    localparam int SRC_PABT = 3;

    localparam logic [3:0] CFG_TARGET = 4'd0;
    localparam logic [3:0] CFG_RETURN = 4'd1;
    localparam logic [3:0] CFG_DELAY  = 4'd2;
    localparam logic [3:0] CFG_LAT    = 4'd3;
    localparam logic [3:0] CFG_MASK   = 4'd4;
    localparam int         CFG_VEC0   = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ARMED, ST_DELAY, ST_ASSERTED,
        ST_WAIT_RET, ST_CHECK_RET, ST_DONE, ST_ERROR
    } iim_state_e;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_NO_MATCH  = 3'd1,
        ERR_WRONG_VEC = 3'd2,
        ERR_LATE_VEC  = 3'd3,
        ERR_WRONG_RET = 3'd4,
        ERR_TIMEOUT   = 3'd5
    } iim_err_e;
endpackage

// File: rtl/iim_cfg_regs.sv
// Configuration register file for the monitor.
// One register is written per cycle. A write takes effect from the next cycle.
// Assumes software loads it while no run is in progress.
module iim_cfg_regs
    import iim_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [3:0]               addr,
    input  logic [AW-1:0]            wdata,
    output logic [AW-1:0]            target,
    output logic [AW-1:0]            ret_exp,
    output logic [DW-1:0]            delay,
    output logic [DW-1:0]            latency,
    output logic [NSRC-1:0]          mask,
    output logic [NSRC-1:0][AW-1:0]  vec
);
    // Holds the scalar configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target  <= '0;
            ret_exp <= '0;
            delay   <= '0;
            latency <= '0;
            mask    <= '0;
        end else if (we) begin
            case (addr)
                CFG_TARGET: target  <= wdata;
                CFG_RETURN: ret_exp <= wdata;
                CFG_DELAY:  delay   <= wdata[DW-1:0];
                CFG_LAT:    latency <= wdata[DW-1:0];
                CFG_MASK:   mask    <= wdata[NSRC-1:0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_vec
        // Holds the handler entry address of source g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vec[g] <= '0;
            else if (we && addr == 4'(CFG_VEC0 + g))
                vec[g] <= wdata;
        end
    end
endmodule

// File: rtl/iim_prio_sel.sv
// Picks the winning source from the mask.
// Priority: data abort, then fast, then normal, then prefetch abort.
// Compares the fetch address against the winner's entry and against all other entries.
// Purely combinational.
module iim_prio_sel
    import iim_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [NSRC-1:0]          mask,
    input  logic [NSRC-1:0][AW-1:0]  vec,
    input  logic [AW-1:0]            addr,
    output logic [NSRC-1:0]          win,
    output logic [AW-1:0]            exp_vec,
    output logic                     hit_exp,
    output logic                     hit_other
);
    // Fixed-priority choice of one source.
    always_comb begin
        win = '0;
        if (mask[SRC_DABT])      win[SRC_DABT] = 1'b1;
        else if (mask[SRC_FIQ])  win[SRC_FIQ]  = 1'b1;
        else if (mask[SRC_IRQ])  win[SRC_IRQ]  = 1'b1;
        else if (mask[SRC_PABT]) win[SRC_PABT] = 1'b1;
    end

    // Entry address of the winner and the address comparisons.
    always_comb begin
        exp_vec   = '0;
        hit_other = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (win[i]) exp_vec = vec[i];
            if (!win[i] && addr == vec[i]) hit_other = 1'b1;
        end
        hit_exp = (win != '0) && (addr == exp_vec);
    end

    // Sanity of the choice against the mask.
    always_comb begin
        AST_WIN_ONEHOT: assert ($onehot0(win)) else $error("winner not one-hot"); // R6
        AST_WIN_IN_MASK: assert ((win & ~mask) == '0) else $error("winner outside mask"); // R6
        AST_WIN_PRESENT: assert ((mask == '0) || (win != '0)) else $error("no winner for nonzero mask"); // R6
    end
endmodule

// File: rtl/irq_inject_monitor.sv
// Interrupt injection and response monitor.
// It watches the core's fetch stream and raises the configured interrupt lines
// a fixed delay after the target fetch. It then checks three things:
// the entry fetch timing, the return fetch after the handler, and the acknowledge.
// Assumes the configuration is stable during a run.
module irq_inject_monitor
    import iim_pkg::*;
#(
    parameter int AW          = 32,
    parameter int DW          = 8,
    parameter int MATCH_LIMIT = 256,
    parameter int RET_LIMIT   = 256,
    parameter int HOLD_LIMIT  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          start,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic          int_ack,
    input  logic          exc_ret,
    output logic [3:0]    int_out,
    output logic          done,
    output logic          pass,
    output logic [2:0]    err_code
);
    localparam int CW = $clog2(MATCH_LIMIT + RET_LIMIT + (1 << DW)) + 1;
    localparam int HW = $clog2(HOLD_LIMIT) + 1;

    logic [AW-1:0]           target, ret_exp, exp_vec;
    logic [DW-1:0]           delay, latency;
    logic [NSRC-1:0]         mask, win, lines;
    logic [NSRC-1:0][AW-1:0] vec;
    logic                    hit_exp, hit_other, line_timeout, enter_assert;
    logic [CW-1:0]           cnt_q, cnt_nxt;
    logic [HW-1:0]           hold_q;
    iim_state_e              st_q, st_nxt;
    iim_err_e                err_q, err_nxt;

    iim_cfg_regs #(.AW(AW), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .target(target), .ret_exp(ret_exp), .delay(delay), .latency(latency),
        .mask(mask), .vec(vec)
    );

    iim_prio_sel #(.AW(AW)) u_prio (
        .mask(mask), .vec(vec), .addr(fetch_addr), .win(win),
        .exp_vec(exp_vec), .hit_exp(hit_exp), .hit_other(hit_other)
    );

    assign line_timeout = (lines != '0) && !int_ack && (hold_q == HW'(HOLD_LIMIT - 1));

    // Next state, cycle counter and error code of the run.
    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        err_nxt = err_q;
        case (st_q)
            ST_IDLE, ST_DONE, ST_ERROR: begin
                if (start) begin
                    st_nxt  = ST_ARMED;
                    cnt_nxt = '0;
                    err_nxt = ERR_NONE;
                end
            end
            ST_ARMED: begin
                if (fetch_valid && fetch_addr == target) begin
                    st_nxt  = (delay == '0) ? ST_ASSERTED : ST_DELAY;
                    cnt_nxt = (delay == '0) ? '0 : CW'(1);
                end else if (cnt_q == CW'(MATCH_LIMIT - 1)) begin
                    st_nxt  = ST_ERROR;
                    err_nxt = ERR_NO_MATCH;
                end else begin
                    cnt_nxt = cnt_q + 1'b1;
                end
            end
            ST_DELAY: begin
                if (cnt_q == CW'(delay)) begin
                    st_nxt  = ST_ASSERTED;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt_q + 1'b1;
                end
            end
            ST_ASSERTED: begin
                if (fetch_valid && hit_exp) begin
                    st_nxt  = ST_WAIT_RET;
                    cnt_nxt = '0;
                end else if (fetch_valid && hit_other) begin
                    st_nxt  = ST_ERROR;
                    err_nxt = ERR_WRONG_VEC;
                end else if (cnt_q == CW'(latency)) begin
                    st_nxt  = ST_ERROR;
                    err_nxt = ERR_LATE_VEC;
                end else begin
                    cnt_nxt = cnt_q + 1'b1;
                end
            end
            ST_WAIT_RET: begin
                if (exc_ret) begin
                    st_nxt = ST_CHECK_RET;
                end else if (cnt_q == CW'(RET_LIMIT - 1)) begin
                    st_nxt  = ST_ERROR;
                    err_nxt = ERR_TIMEOUT;
                end else begin
                    cnt_nxt = cnt_q + 1'b1;
                end
            end
            ST_CHECK_RET: begin
                if (fetch_valid) begin
                    st_nxt  = (fetch_addr == ret_exp) ? ST_DONE : ST_ERROR;
                    err_nxt = (fetch_addr == ret_exp) ? ERR_NONE : ERR_WRONG_RET;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
        if (line_timeout) begin
            st_nxt  = ST_ERROR;
            err_nxt = ERR_TIMEOUT;
        end
    end

    assign enter_assert = (st_q != ST_ASSERTED) && (st_nxt == ST_ASSERTED);

    // State, counter and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            err_q <= ERR_NONE;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_nxt;
            err_q <= err_nxt;
        end
    end

    // Interrupt lines: raised on entry to the window, dropped on acknowledge or end of run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lines <= '0;
        else if (st_nxt == ST_DONE || st_nxt == ST_ERROR)
            lines <= '0;
        else if (enter_assert)
            lines <= mask;
        else if (int_ack)
            lines <= '0;
    end

    // Counts the cycles the lines have been high.
    always_ff @(posedge clk) begin
        if (!rst_n || lines == '0)
            hold_q <= '0;
        else
            hold_q <= hold_q + 1'b1;
    end

    assign int_out  = lines;
    assign done     = (st_q == ST_DONE) || (st_q == ST_ERROR);
    assign pass     = (st_q == ST_DONE);
    assign err_code = err_q;

    AST_QUIET_BEFORE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE || st_q == ST_ARMED || st_q == ST_DELAY) |-> (int_out == '0)); // R2
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (int_out != '0 && int_ack) |=> (int_out == '0)); // R4
    AST_LINES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (int_out != '0 && !int_ack) |=> (int_out == $past(int_out) || done)); // R4
    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int_out != '0) |-> (hold_q <= HW'(HOLD_LIMIT - 1))); // R5
    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (done && err_code == ERR_NONE)); // R9
    AST_FAIL_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> (err_code != ERR_NONE)); // R12
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(err_code))); // R12
endmodule

// File: tb/irq_inject_monitor_test.sv
module irq_inject_monitor_test;
    localparam logic [31:0] TGT = 32'h0000_4000;
    localparam logic [31:0] RET = 32'h0000_4004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        int_ack = 1'b0;
    logic        exc_ret = 1'b0;
    logic [3:0]  int_out;
    logic        done, pass;
    logic [2:0]  err_code;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    irq_inject_monitor uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .int_ack(int_ack), .exc_ret(exc_ret),
        .int_out(int_out), .done(done), .pass(pass), .err_code(err_code)
    );

    function automatic logic [31:0] vec_of(int i);
        return 32'h20 + 32'(i) * 8;
    endfunction

    function automatic int winner(int m);
        if (m[2]) return 2;
        if (m[1]) return 1;
        if (m[0]) return 0;
        return 3;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Loads a run's configuration through the R11 map, starts the run and fires the trigger.
    task automatic setup_and_fire(int t, int m, int a);
        wr(4'd0, TGT); wr(4'd1, RET); wr(4'd2, 32'(t)); wr(4'd3, 32'(a)); wr(4'd4, 32'(m));
        for (int i = 0; i < 4; i++) wr(4'(5 + i), vec_of(i));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R12 start clears done", 32'(done), 32'd0);
        fetch_valid = 1'b1; fetch_addr = TGT + 32'd8;
        @(negedge clk);
        chk(int_out == 4'd0, "R2 non-target fetch raises nothing", 32'(int_out), 32'd0);
        fetch_addr = TGT;
        for (int k = 0; k <= t; k++) begin
            @(negedge clk);
            if (k == 0) fetch_valid = 1'b0;
            if (k == t)
                chk(int_out == 4'(m), "R3 lines equal mask at m+1+T (R2)", 32'(int_out), 32'(m));
            else
                chk(int_out == 4'd0, "R2 lines low during delay", 32'(int_out), 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        chk(done == 0 && pass == 0 && err_code == 0 && int_out == 0, "R1 reset state",
            {done, pass, err_code, int_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 0 && pass == 0 && err_code == 0 && int_out == 0, "R1 after release",
            {done, pass, err_code, int_out}, 32'd0);

        // Main sweep over R6/R7/R9 boundaries.
        for (int t = 0; t < 4; t++)
            for (int m = 1; m < 16; m++)
                for (int a = 0; a < 4; a++)
                    for (int vc = 0; vc <= a + 1; vc++) begin
                        bit bad = ((t + m + vc) % 3) == 0;
                        setup_and_fire(t, m, a);
                        if (vc <= a) begin
                            repeat (vc) @(negedge clk);
                            fetch_valid = 1'b1; fetch_addr = vec_of(winner(m)); int_ack = 1'b1;
                            @(negedge clk);
                            fetch_valid = 1'b0; int_ack = 1'b0;
                            chk(int_out == 0 && done == 0, "R4/R6 entry accepted, lines drop on ack",
                                {done, int_out}, 32'd0);
                            exc_ret = 1'b1;
                            @(negedge clk);
                            exc_ret = 1'b0;
                            fetch_valid = 1'b1; fetch_addr = bad ? RET + 32'd4 : RET;
                            @(negedge clk);
                            fetch_valid = 1'b0;
                            chk(done && pass == !bad && err_code == (bad ? 3'd4 : 3'd0),
                                "R9 return check", {done, pass, err_code},
                                {1'b1, !bad, (bad ? 3'd4 : 3'd0)});
                        end else begin
                            repeat (a + 1) @(negedge clk);
                            chk(done && !pass && err_code == 3'd3 && int_out == 0,
                                "R7 late entry", {done, pass, err_code, int_out},
                                {1'b1, 1'b0, 3'd3, 4'd0});
                        end
                    end

        // R8: fetch of a non-winning entry address.
        for (int m = 1; m < 16; m++) begin
            setup_and_fire(0, m, 3);
            fetch_valid = 1'b1; fetch_addr = vec_of((winner(m) + 1) % 4);
            @(negedge clk);
            fetch_valid = 1'b0;
            chk(done && err_code == 3'd2 && int_out == 0, "R8 wrong entry",
                {done, err_code, int_out}, {1'b1, 3'd2, 4'd0});
        end

        // R5: no acknowledge, lines time out after 64 high cycles.
        setup_and_fire(0, 1, 3);
        fetch_valid = 1'b1; fetch_addr = vec_of(0);
        for (int c = 1; c <= 64; c++) begin
            @(negedge clk);
            if (c == 1) fetch_valid = 1'b0;
            if (c == 63)
                chk(int_out == 4'd1 && !done, "R5 lines still high at cycle 63",
                    {done, int_out}, 32'd1);
            if (c == 64)
                chk(done && err_code == 3'd5 && int_out == 0, "R5 timeout",
                    {done, err_code, int_out}, {1'b1, 3'd5, 4'd0});
        end

        // R10: no target fetch within the match window.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (255) @(negedge clk);
        chk(!done, "R10 still armed at cycle 255", 32'(done), 32'd0);
        @(negedge clk);
        chk(done && err_code == 3'd1, "R10 no match", {done, err_code}, {1'b1, 3'd1});
        repeat (3) @(negedge clk);
        chk(done && err_code == 3'd1, "R12 result held", {done, err_code}, {1'b1, 3'd1});

        report();
        $finish;
    end
endmodule